// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is the digital sequencing logic of a linear light-sensor array with a configurable number of pixels (64 by default). A start strobe, sampled high on a rising clock edge while the block is idle, launches an output frame. A single token then walks through a chain of stages, one stage per clock, so that exactly one pixel-select line is high at any time. While the frame runs, an output-enable stands in for the analog output driver. When the frame ends that enable drops, which models the output going to high impedance. Analog behaviour is out of scope: the selected pixel is reported only as a one-hot index.

Counting the starting edge as edge 1, pixel k is selected after edge k+1. The token appears on the serial output after edge N, alongside the last pixel, so that output can start a second device wired in series. Edge N+1 clears the chain, drops the enable and issues a one-cycle frame-done pulse. A new start is accepted at the earliest on edge N+2. A start strobe seen while a frame is running is ignored and raises a one-cycle overrun pulse. The block also produces a sense-node reset strobe in every clock period and a sample/hold control that samples while the clock is high.

The reset input is asynchronous and active-low. Its release passes through a synchronizer, so the block leaves reset on a clock edge.

Top module: `lsr_seq`

## Requirements
- R1: While reset is applied, and after its release with no start, pix_sel_o is all zero and out_en_o, so_o, done_o, ovr_o and sh_o are 0.
- R2: When si_i is 1 at a rising edge while out_en_o is 0, bit 0 of pix_sel_o and out_en_o are 1 after that edge.
- R3: At each later rising edge of a frame, the single 1 in pix_sel_o moves from bit k to bit k+1, and pix_sel_o is never more than one-hot.
- R4: so_o is 1 for exactly one cycle: after edge N of a frame (the starting edge counted as edge 1), together with bit N-1 of pix_sel_o.
- R5: After edge N+1, pix_sel_o is zero, out_en_o is 0 and done_o is 1 for that one cycle.
- R6: A 1 on si_i at edges 2 through N+1 of a frame does not change the selection sequence, and it makes ovr_o 1 for the cycle after that edge.
- R7: A 1 on si_i at edge N+2 starts a new frame, with bit 0 of pix_sel_o set after that edge.
- R8: sn_rst_o is 1 while clk_i is low and 0 while it is high, in every clock period.
- R9: sh_o is 1 while clk_i is high and out_en_o is 1, and 0 while clk_i is low.
- R10: When so_o of one device drives si_i of a second device, the second device selects its bit 0 after the same edge at which the first device issues done_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| si_i | input | 1 | Serial start strobe |
| pix_sel_o | output | NUM_PIX | One-hot selected pixel |
| out_en_o | output | 1 | Analog output drive enable (0 = high impedance) |
| sn_rst_o | output | 1 | Sense-node reset strobe, high in the low clock phase |
| sh_o | output | 1 | Sample/hold control, 1 = sample |
| so_o | output | 1 | Serial token output for a following device |
| done_o | output | 1 | One-cycle frame-complete pulse |
| ovr_o | output | 1 | One-cycle pulse when a start is ignored during a frame |

## Verification
The bench builds two instances with the default of 64 pixels, the second fed by the first one's serial output. With the full frame length, the boundary edges 64, 65 and 66 and the handoff between the two devices are all exercised at their true positions. Holding the start strobe high across a whole frame probes every busy edge for overrun and also the earliest legal restart, and a reset in mid-frame shows that the chain returns to idle.

// File: rtl/lsr_seq_pkg.sv
package lsr_seq_pkg;
  localparam int unsigned DEF_NUM_PIX  = 64;
  localparam int unsigned DEF_SYNC_STG = 2;

  typedef struct packed {
    logic so;
    logic done;
    logic ovr;
  } frm_evt_t;
endpackage

// File: rtl/lsr_rst_sync.sv
module lsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/lsr_token_chain.sv
module lsr_token_chain #(
  parameter int unsigned NUM_PIX = 64
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               load_i,
  output logic [NUM_PIX-1:0] tok_o,
  output logic               busy_o
);
  logic [NUM_PIX-1:0] tok_q;
  logic [NUM_PIX-1:0] tok_d;
  logic               adv_en;

  always_comb begin
    adv_en = load_i | busy_o;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PIX; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_comb tok_d[g] = load_i;
      end else begin : g_body
        always_comb tok_d[g] = tok_q[g-1];
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)    tok_q[g] <= 1'b0;
        else if (adv_en) tok_q[g] <= tok_d[g];
      end
    end
  endgenerate

  assign tok_o  = tok_q;
  assign busy_o = |tok_q;
endmodule

// File: rtl/lsr_frame_ctrl.sv
module lsr_frame_ctrl
  import lsr_seq_pkg::*;
#(
  parameter int unsigned NUM_PIX = 64
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               si_i,
  input  logic [NUM_PIX-1:0] tok_i,
  input  logic               busy_i,
  output logic               load_o,
  output frm_evt_t           evt_o
);
  logic     last_stage;
  frm_evt_t evt_q;
  frm_evt_t evt_d;

  always_comb begin
    last_stage = tok_i[NUM_PIX-1];
    load_o     = si_i & ~busy_i;
    evt_d.so   = 1'b0;
    evt_d.done = last_stage;
    evt_d.ovr  = si_i & busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      evt_q.done <= 1'b0;
      evt_q.ovr  <= 1'b0;
      evt_q.so   <= 1'b0;
    end else begin
      evt_q.done <= evt_d.done;
      evt_q.ovr  <= evt_d.ovr;
      evt_q.so   <= evt_d.so;
    end
  end

  always_comb begin
    evt_o      = evt_q;
    evt_o.so   = last_stage;
  end
endmodule

// File: rtl/lsr_phase_gen.sv
module lsr_phase_gen (
  input  logic clk_i,
  input  logic out_en_i,
  output logic sn_rst_o,
  output logic sh_o
);
  always_comb begin
    sn_rst_o = ~clk_i;
    sh_o     = clk_i & out_en_i;
  end
endmodule

// File: rtl/lsr_seq.sv
module lsr_seq
  import lsr_seq_pkg::*;
#(
  parameter int unsigned NUM_PIX  = DEF_NUM_PIX,
  parameter int unsigned SYNC_STG = DEF_SYNC_STG
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               si_i,
  output logic [NUM_PIX-1:0] pix_sel_o,
  output logic               out_en_o,
  output logic               sn_rst_o,
  output logic               sh_o,
  output logic               so_o,
  output logic               done_o,
  output logic               ovr_o
);
  logic               core_rst_n;
  logic               load;
  logic               busy;
  logic [NUM_PIX-1:0] tok;
  frm_evt_t           evt;

  lsr_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (core_rst_n)
  );

  lsr_token_chain #(.NUM_PIX(NUM_PIX)) u_chain (
    .clk_i   (clk_i),
    .rst_n_i (core_rst_n),
    .load_i  (load),
    .tok_o   (tok),
    .busy_o  (busy)
  );

  lsr_frame_ctrl #(.NUM_PIX(NUM_PIX)) u_ctrl (
    .clk_i   (clk_i),
    .rst_n_i (core_rst_n),
    .si_i    (si_i),
    .tok_i   (tok),
    .busy_i  (busy),
    .load_o  (load),
    .evt_o   (evt)
  );

  lsr_phase_gen u_phase (
    .clk_i    (clk_i),
    .out_en_i (busy),
    .sn_rst_o (sn_rst_o),
    .sh_o     (sh_o)
  );

  assign pix_sel_o = tok;
  assign out_en_o  = busy;
  assign so_o      = evt.so;
  assign done_o    = evt.done;
  assign ovr_o     = evt.ovr;
endmodule

// File: rtl/lsr_seq_chk.sv
module lsr_seq_chk #(
  parameter int unsigned NUM_PIX = 64
) (
  input logic               clk_i,
  input logic               core_rst_n,
  input logic               si_i,
  input logic [NUM_PIX-1:0] pix_sel_o,
  input logic               out_en_o,
  input logic               so_o,
  input logic               done_o,
  input logic               ovr_o
);
  // R3
  onehot_sel_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    $onehot0(pix_sel_o));

  // R2
  start_sel_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (!out_en_o && si_i) |=> (pix_sel_o[0] && out_en_o));

  // R3
  advance_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (out_en_o && !pix_sel_o[NUM_PIX-1]) |=> (pix_sel_o == ($past(pix_sel_o) << 1)));

  // R5
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    pix_sel_o[NUM_PIX-1] |=> (!out_en_o && done_o && (pix_sel_o == '0)));

  // R4
  so_done_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    so_o |=> (done_o && !so_o));

  // R6
  overrun_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (out_en_o && si_i) |=> ovr_o);
endmodule

bind lsr_seq lsr_seq_chk #(.NUM_PIX(NUM_PIX)) u_chk (
  .clk_i      (clk_i),
  .core_rst_n (core_rst_n),
  .si_i       (si_i),
  .pix_sel_o  (pix_sel_o),
  .out_en_o   (out_en_o),
  .so_o       (so_o),
  .done_o     (done_o),
  .ovr_o      (ovr_o)
);

// File: tb/lsr_seq_tb.sv
module lsr_seq_tb;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         si = 1'b0;
  logic [N-1:0] pix_sel, pix_sel2;
  logic         out_en, sn_rst, sh, so, done, ovr;
  logic         out_en2, sn_rst2, sh2, so2, done2, ovr2;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int           pos = -1;
  logic [N-1:0] e_sel = '0;
  logic         e_en = 1'b0, e_so = 1'b0, e_done = 1'b0, e_ovr = 1'b0;

  always #5 clk = ~clk;

  lsr_seq #(.NUM_PIX(N)) u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .si_i(si), .pix_sel_o(pix_sel),
    .out_en_o(out_en), .sn_rst_o(sn_rst), .sh_o(sh), .so_o(so),
    .done_o(done), .ovr_o(ovr));

  lsr_seq #(.NUM_PIX(N)) u_casc (
    .clk_i(clk), .rst_n_i(rst_n), .si_i(so), .pix_sel_o(pix_sel2),
    .out_en_o(out_en2), .sn_rst_o(sn_rst2), .sh_o(sh2), .so_o(so2),
    .done_o(done2), .ovr_o(ovr2));

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // Behavioural reference: frame position as an integer, -1 when idle.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      pos = -1; e_done = 1'b0; e_ovr = 1'b0;
    end else begin
      e_ovr  = si && (pos >= 0);
      e_done = (pos == N-1);
      if (pos == N-1)            pos = -1;
      else if (pos >= 0)         pos = pos + 1;
      else if (si)               pos = 0;
    end
    e_en  = (pos >= 0);
    e_sel = e_en ? ({{(N-1){1'b0}}, 1'b1} << pos) : '0;
    e_so  = (pos == N-1);
  end

  // Low-phase comparison.
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 sel in reset", pix_sel, '0);
      chk("R1 en in reset", {63'b0, out_en}, '0);
    end
    chk("R2 R3 pix_sel", pix_sel, e_sel);
    chk("R2 R5 out_en", {63'b0, out_en}, {63'b0, e_en});
    chk("R4 so", {63'b0, so}, {63'b0, e_so});
    chk("R5 done", {63'b0, done}, {63'b0, e_done});
    chk("R6 ovr", {63'b0, ovr}, {63'b0, e_ovr});
    chk("R8 sn_rst low phase", {63'b0, sn_rst}, {63'b0, 1'b1});
    chk("R9 sh low phase", {63'b0, sh}, '0);
    if (e_done)
      chk("R10 cascade first pixel", {63'b0, pix_sel2[0]}, {63'b0, 1'b1});
  end

  // High-phase comparison.
  always @(posedge clk) begin
    #2;
    chk("R8 sn_rst high phase", {63'b0, sn_rst}, '0);
    chk("R9 sh high phase", {63'b0, sh}, {63'b0, e_en});
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_pulse();
    @(negedge clk); #1 si = 1'b1;
    @(negedge clk); #1 si = 1'b0;
  endtask

  initial begin
    // R1: reset state
    idle(3);
    #1 rst_n = 1'b1;
    idle(5);
    chk("R1 idle sh", {63'b0, sh}, '0);

    // R2 R3 R4 R5: single frame
    start_pulse();
    idle(70);

    // R6 R7: strobe held high over a full frame and beyond
    @(negedge clk); #1 si = 1'b1;
    idle(70);
    #1 si = 1'b0;
    idle(70);

    // R6: isolated pulses in mid-frame
    start_pulse();
    idle(10);
    start_pulse();
    idle(30);
    start_pulse();
    idle(40);

    // R1: reset in mid-frame, then a fresh frame
    start_pulse();
    idle(20);
    #1 rst_n = 1'b0;
    idle(3);
    #1 rst_n = 1'b1;
    idle(5);
    chk("R1 after mid-frame reset", pix_sel, '0);
    start_pulse();
    idle(70);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired at cycle %0d: actual hang expected finish", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule